// File: doc/BRIEF.md
# YUV Overlay Blender with Output Clipping

This block sits in the pixel path of a video output unit. Each beat carries one base pixel and one overlay pixel. Each pixel has a luma value and the two chroma values of its 4:2:2 sample pair. The overlay pixel also has an 8-bit alpha. The block mixes the overlay over the base with 129 graded weights. It treats an overlay colour that equals a programmed key as fully transparent. It then limits luma and chroma to separate programmable bounds.

One control bit turns the mixing, the keying and the limiting on or off together. With that bit cleared, the base pixel passes through untouched, which is the legacy path. The path is a fixed two-register pipeline qualified by a valid strobe. A small word-wide register port sets the control bit, the key colour and the limits.

Top module: `yuv_ovl_blend`

## Requirements
- R1: After reset, the control word reads 0x10000000, the key word reads 0 and the limits word reads 0xF010EB10. out_valid is low.
- R2: The register map is as follows. Address 0 is control, with the enable at bit 28. Address 1 is the key, with Y in [7:0], Cb in [15:8] and Cr in [23:16]. Address 2 is the limits word, with luma low in [7:0], luma high in [15:8], chroma low in [23:16] and chroma high in [31:24]. Undefined bits read as zero and ignore writes. Address 3 always reads zero.
- R3: A pixel is accepted on a rising edge with in_valid high. Its result is on the outputs after the next rising edge, with out_valid high. Pixels may arrive back to back. out_valid is low in every cycle that has no result.
- R4: When enabled, the alpha maps to a weight w = (alpha + alpha[7]) >> 1 in the range 0..128. Each component becomes (w*overlay + (128-w)*base + 64) >> 7, and is then limited.
- R5: An alpha of 0 gives the base pixel and an alpha of 255 gives the overlay pixel, before limiting.
- R6: When enabled, an overlay whose Y, Cb and Cr all equal the key fields outputs the base pixel, whatever its alpha. A difference in any one field gives the normal mix.
- R7: When enabled, Y is limited to [luma low, luma high] and Cb and Cr are limited to [chroma low, chroma high]. The low bound is applied first and the high bound second, so the high bound wins when low is greater than high.
- R8: With the enable at 0, the outputs equal the base pixel. The overlay, the alpha, the key and the limits have no effect.
- R9: A register write lands on the same edge that accepts a pixel. That pixel still uses the old settings, and every later pixel uses the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| in_valid | input | 1 | Input pixel valid |
| base_y | input | 8 | Base luma |
| base_cb | input | 8 | Base Cb of the sample pair |
| base_cr | input | 8 | Base Cr of the sample pair |
| ovl_y | input | 8 | Overlay luma |
| ovl_cb | input | 8 | Overlay Cb of the sample pair |
| ovl_cr | input | 8 | Overlay Cr of the sample pair |
| ovl_alpha | input | 8 | Overlay alpha |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Result luma |
| out_cb | output | 8 | Result Cb |
| out_cr | output | 8 | Result Cr |

## Verification
The assertions assume that in_valid and the pixel inputs are known on every sampled edge after reset. The limit check also assumes that the bounds it reads from two cycles earlier match the ones the pixel used, which holds because settings are captured together with each pixel. The bench drives every input at the falling edge and keeps in_valid at a defined level at all times. It writes registers only between pixels, except in the one scenario built to probe write timing. The alpha-zero property only claims pass-through for base values inside the limits, and the stimulus that hits it keeps to that case.

// File: rtl/yob_pkg.sv
package yob_pkg;
  localparam int PIX_W   = 8;
  localparam int NCOMP   = 3;
  localparam int KEY_W   = NCOMP * PIX_W;
  localparam int CLIP_W  = 4 * PIX_W;
  localparam int CFG_AW  = 2;
  localparam int CFG_DW  = 32;
  localparam int EN_BIT  = 28;
  localparam int W_SHIFT = PIX_W - 1;

  typedef logic [PIX_W-1:0] comp_t;
  typedef struct packed {
    comp_t y;
    comp_t cb;
    comp_t cr;
  } yuv_t;

  localparam logic [CFG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [CFG_AW-1:0] ADDR_KEY  = 2'd1;
  localparam logic [CFG_AW-1:0] ADDR_CLIP = 2'd2;

  localparam logic [CLIP_W-1:0] CLIP_RST = 32'hF010EB10;
endpackage

// File: rtl/yob_cfg_regs.sv
module yob_cfg_regs
  import yob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output logic              en,
  output yuv_t              key,
  output logic [CLIP_W-1:0] clip
);
  logic              en_q, en_d;
  yuv_t              key_q, key_d;
  logic [CLIP_W-1:0] clip_q, clip_d;

  always_comb begin
    en_d   = en_q;
    key_d  = key_q;
    clip_d = clip_q;
    if (we) begin
      case (addr)
        ADDR_CTRL: en_d = wdata[EN_BIT];
        ADDR_KEY: begin
          key_d.y  = wdata[0*PIX_W +: PIX_W];
          key_d.cb = wdata[1*PIX_W +: PIX_W];
          key_d.cr = wdata[2*PIX_W +: PIX_W];
        end
        ADDR_CLIP: clip_d = wdata[CLIP_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b1;
      key_q  <= '0;
      clip_q <= CLIP_RST;
    end else begin
      en_q   <= en_d;
      key_q  <= key_d;
      clip_q <= clip_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: rdata[EN_BIT] = en_q;
      ADDR_KEY:  rdata[KEY_W-1:0] = {key_q.cr, key_q.cb, key_q.y};
      ADDR_CLIP: rdata[CLIP_W-1:0] = clip_q;
      default:   rdata = '0;
    endcase
  end

  assign en   = en_q;
  assign key  = key_q;
  assign clip = clip_q;
endmodule

// File: rtl/yob_front.sv
module yob_front
  import yob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  yuv_t              base,
  input  yuv_t              ovl,
  input  logic [PIX_W-1:0]  alpha,
  input  logic              en,
  input  yuv_t              key,
  input  logic [CLIP_W-1:0] clip,
  output logic              s1_valid,
  output logic              s1_en,
  output logic [PIX_W-1:0]  s1_w,
  output yuv_t              s1_base,
  output yuv_t              s1_ovl,
  output logic [CLIP_W-1:0] s1_clip
);
  logic [PIX_W:0]   a_sum;
  logic [PIX_W-1:0] w_d;
  logic             key_hit;
  logic             unused_lsb;

  always_comb begin
    a_sum   = {1'b0, alpha} + {{PIX_W{1'b0}}, alpha[PIX_W-1]};
    key_hit = (ovl == key);
    w_d     = key_hit ? '0 : a_sum[PIX_W:1];
  end
  assign unused_lsb = a_sum[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_en    <= 1'b0;
      s1_w     <= '0;
      s1_base  <= '0;
      s1_ovl   <= '0;
      s1_clip  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_en   <= en;
        s1_w    <= w_d;
        s1_base <= base;
        s1_ovl  <= ovl;
        s1_clip <= clip;
      end
    end
  end
endmodule

// File: rtl/yob_mix.sv
module yob_mix
  import yob_pkg::*;
(
  input  logic             en,
  input  logic [PIX_W-1:0] w,
  input  comp_t            base,
  input  comp_t            ovl,
  input  comp_t            lo,
  input  comp_t            hi,
  output comp_t            res
);
  localparam int AW   = 2 * PIX_W - 1;
  localparam int FULL = 1 << W_SHIFT;

  logic [AW-1:0] w_x, inv_x, acc;
  comp_t         mixed, floored, capped;
  logic          unused_frac;

  always_comb begin
    w_x     = AW'(w);
    inv_x   = AW'(FULL) - w_x;
    acc     = w_x * AW'(ovl) + inv_x * AW'(base) + AW'(FULL / 2);
    mixed   = acc[W_SHIFT +: PIX_W];
    floored = (mixed < lo) ? lo : mixed;
    capped  = (floored > hi) ? hi : floored;
    res     = en ? capped : base;
  end
  assign unused_frac = ^acc[W_SHIFT-1:0];
endmodule

// File: rtl/yuv_ovl_blend.sv
module yuv_ovl_blend
  import yob_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  base_y,
  input  logic [PIX_W-1:0]  base_cb,
  input  logic [PIX_W-1:0]  base_cr,
  input  logic [PIX_W-1:0]  ovl_y,
  input  logic [PIX_W-1:0]  ovl_cb,
  input  logic [PIX_W-1:0]  ovl_cr,
  input  logic [PIX_W-1:0]  ovl_alpha,
  output logic              out_valid,
  output logic [PIX_W-1:0]  out_y,
  output logic [PIX_W-1:0]  out_cb,
  output logic [PIX_W-1:0]  out_cr
);
  logic              cfg_en;
  yuv_t              cfg_key;
  logic [CLIP_W-1:0] cfg_clip;

  yob_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .en(cfg_en), .key(cfg_key), .clip(cfg_clip)
  );

  yuv_t base_px, ovl_px;
  assign base_px = {base_y, base_cb, base_cr};
  assign ovl_px  = {ovl_y, ovl_cb, ovl_cr};

  logic              s1_valid, s1_en;
  logic [PIX_W-1:0]  s1_w;
  yuv_t              s1_base, s1_ovl;
  logic [CLIP_W-1:0] s1_clip;

  yob_front u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .base(base_px), .ovl(ovl_px), .alpha(ovl_alpha),
    .en(cfg_en), .key(cfg_key), .clip(cfg_clip),
    .s1_valid(s1_valid), .s1_en(s1_en), .s1_w(s1_w),
    .s1_base(s1_base), .s1_ovl(s1_ovl), .s1_clip(s1_clip)
  );

  comp_t b_arr [NCOMP];
  comp_t o_arr [NCOMP];
  comp_t m_arr [NCOMP];
  assign b_arr = '{s1_base.y, s1_base.cb, s1_base.cr};
  assign o_arr = '{s1_ovl.y, s1_ovl.cb, s1_ovl.cr};

  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    localparam int LO_IDX = (c == 0) ? 0 : 2;
    yob_mix u_mix (
      .en(s1_en), .w(s1_w), .base(b_arr[c]), .ovl(o_arr[c]),
      .lo(s1_clip[LO_IDX*PIX_W +: PIX_W]),
      .hi(s1_clip[(LO_IDX+1)*PIX_W +: PIX_W]),
      .res(m_arr[c])
    );
  end

  logic valid_q;
  yuv_t out_q, out_d;
  assign out_d = {m_arr[0], m_arr[1], m_arr[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      valid_q <= s1_valid;
      if (s1_valid) out_q <= out_d;
    end
  end

  assign out_valid = valid_q;
  assign out_y     = out_q.y;
  assign out_cb    = out_q.cb;
  assign out_cr    = out_q.cr;
endmodule

// File: rtl/yob_chk.sv
module yob_chk
  import yob_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [PIX_W-1:0]  base_y,
  input logic [PIX_W-1:0]  base_cb,
  input logic [PIX_W-1:0]  base_cr,
  input logic [PIX_W-1:0]  ovl_alpha,
  input logic              cfg_en,
  input logic [CLIP_W-1:0] cfg_clip,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [CFG_DW-1:0] cfg_rdata,
  input logic              out_valid,
  input logic [PIX_W-1:0]  out_y,
  input logic [PIX_W-1:0]  out_cb,
  input logic [PIX_W-1:0]  out_cr
);
  logic [PIX_W-1:0] y_lo, y_hi;
  assign y_lo = cfg_clip[0 +: PIX_W];
  assign y_hi = cfg_clip[PIX_W +: PIX_W];

  // R3
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  // R3
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  // R8
  legacy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(cfg_en, 2)) |->
      (out_y == $past(base_y, 2) && out_cb == $past(base_cb, 2) &&
       out_cr == $past(base_cr, 2)));

  // R7
  luma_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_en, 2) && $past(y_lo <= y_hi, 2)) |->
      (out_y >= $past(y_lo, 2) && out_y <= $past(y_hi, 2)));

  // R5
  zero_alpha_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && cfg_en && ovl_alpha == '0 &&
          base_y >= y_lo && base_y <= y_hi, 2) |->
      (out_valid && out_y == $past(base_y, 2)));

  // R2
  undef_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd3) |-> (cfg_rdata == '0));
endmodule

bind yuv_ovl_blend yob_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .base_y(base_y), .base_cb(base_cb), .base_cr(base_cr),
  .ovl_alpha(ovl_alpha), .cfg_en(cfg_en), .cfg_clip(cfg_clip),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
);

// File: tb/yuv_ovl_blend_test.sv
`timescale 1ns/1ps
module yuv_ovl_blend_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        in_valid;
  logic [7:0]  base_y, base_cb, base_cr, ovl_y, ovl_cb, ovl_cr, ovl_alpha;
  logic        out_valid;
  logic [7:0]  out_y, out_cb, out_cr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  yuv_ovl_blend uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int mixv(input int a, input int b, input int o);
    int w;
    w = (a + (a >> 7)) >> 1;
    return (w * o + (128 - w) * b + 64) >> 7;
  endfunction

  function automatic int lim(input int v, input int lo, input int hi);
    int t;
    t = (v < lo) ? lo : v;
    return (t > hi) ? hi : t;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic drive(input logic [7:0] by, bcb, bcr, oy, ocb, ocr, al);
    base_y = by; base_cb = bcb; base_cr = bcr;
    ovl_y = oy; ovl_cb = ocb; ovl_cr = ocr; ovl_alpha = al;
    in_valid = 1'b1;
  endtask

  // one pixel, result read one falling edge after the second rising edge
  task automatic pix(input string req, input logic [7:0] by, bcb, bcr,
                     oy, ocb, ocr, al, input int ey, ecb, ecr);
    @(negedge clk);
    drive(by, bcb, bcr, oy, ocb, ocr, al);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid not early"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " y"},  32'(out_y),  32'(ey));
    chk({req, " cb"}, 32'(out_cb), 32'(ecb));
    chk({req, " cr"}, 32'(out_cr), 32'(ecr));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    rd(2'd0, d); chk("R1 ctrl", d, 32'h10000000);
    rd(2'd1, d); chk("R1 key", d, 32'h0);
    rd(2'd2, d); chk("R1 clip", d, 32'hF010EB10);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(2'd0, 32'hFFFFFFFF); rd(2'd0, d); chk("R2 ctrl undefined bits", d, 32'h10000000);
    wr(2'd1, 32'hFFFFFFFF); rd(2'd1, d); chk("R2 key undefined bits", d, 32'h00FFFFFF);
    wr(2'd3, 32'hFFFFFFFF); rd(2'd3, d); chk("R2 addr3 zero", d, 32'h0);
    rd(2'd2, d); chk("R2 clip untouched by addr3", d, 32'hF010EB10);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_endpoints;
    wr(2'd2, 32'hFF00FF00);
    pix("R5 alpha0", 8'd200, 8'd100, 8'd50, 8'd40, 8'd220, 8'd130, 8'd0, 200, 100, 50);
    pix("R5 alpha255", 8'd200, 8'd100, 8'd50, 8'd40, 8'd220, 8'd130, 8'd255, 40, 220, 130);
  endtask

  task automatic t_blend;
    int al [4] = '{128, 127, 1, 200};
    foreach (al[i]) begin
      pix("R4 mix", 8'd200, 8'd100, 8'd50, 8'd40, 8'd220, 8'd130, 8'(al[i]),
          mixv(al[i], 200, 40), mixv(al[i], 100, 220), mixv(al[i], 50, 130));
    end
  endtask

  task automatic t_key;
    wr(2'd1, 32'h00805A30);  // Cr 0x80, Cb 0x5A, Y 0x30
    pix("R6 key hit", 8'd10, 8'd20, 8'd30, 8'h30, 8'h5A, 8'h80, 8'd255, 10, 20, 30);
    pix("R6 key cb miss", 8'd10, 8'd20, 8'd30, 8'h30, 8'h5B, 8'h80, 8'd255, 48, 91, 128);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_clip;
    wr(2'd2, 32'hF010EB10);
    pix("R7 low", 8'd5, 8'd3, 8'd250, 8'd0, 8'd0, 8'd0, 8'd0, 16, 16, 240);
    pix("R7 high", 8'd250, 8'd245, 8'd100, 8'd0, 8'd0, 8'd0, 8'd0, 235, 240, 100);
    wr(2'd2, 32'h20F064C8);  // luma lo 200 hi 100, chroma lo 240 hi 32
    pix("R7 inverted", 8'd150, 8'd150, 8'd150, 8'd0, 8'd0, 8'd0, 8'd0, 100, 32, 32);
    wr(2'd2, 32'hF010EB10);
  endtask

  task automatic t_legacy;
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h00000000);
    pix("R8 bypass", 8'd3, 8'd250, 8'd7, 8'd0, 8'd0, 8'd0, 8'd255, 3, 250, 7);
    pix("R8 key and alpha ignored", 8'd240, 8'd1, 8'd2, 8'd9, 8'd9, 8'd9, 8'd128, 240, 1, 2);
    wr(2'd0, 32'h10000000);
  endtask

  task automatic t_write_timing;
    wr(2'd2, 32'hFF00FF00);
    @(negedge clk);
    drive(8'd200, 8'd100, 8'd50, 8'd40, 8'd220, 8'd130, 8'd255);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R9 old setting y", 32'(out_y), 32'd40);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 next pixel y", 32'(out_y), 32'd200);
    chk("R9 next pixel valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    wr(2'd0, 32'h10000000);
  endtask

  task automatic t_stream;
    int a [4] = '{0, 255, 64, 0};
    int b [4] = '{60, 61, 62, 63};
    wr(2'd2, 32'hFF00FF00);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      drive(8'(b[i]), 8'd90, 8'd90, 8'd180, 8'd90, 8'd90, 8'(a[i]));
      @(negedge clk);
      if (i >= 1) chk("R3 stream y", 32'(out_y), 32'(mixv(a[i-1], b[i-1], 180)));
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R3 stream last y", 32'(out_y), 32'(mixv(a[3], b[3], 180)));
    chk("R3 stream last valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    chk("R3 valid drops", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    in_valid = 1'b0;
    base_y = '0; base_cb = '0; base_cr = '0;
    ovl_y = '0; ovl_cb = '0; ovl_cr = '0; ovl_alpha = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_endpoints;
    t_blend;
    t_key;
    t_clip;
    t_legacy;
    t_write_timing;
    t_stream;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule